// File: doc/BRIEF.md
# TFT Panel Control Line Output Stage

This block drives the special control outputs of a TFT panel: two control lines and a shift clock whose active edge can be chosen. A four-bit control register sets its behaviour. The register chooses how the second control line behaves, starts or stops a position counter, picks the shift clock edge, and can exchange the two control lines at the pins. The position counter restarts on every line pulse from the timing generator and counts pixel-clock cycles within the line.

The first control line is set and cleared at two programmed counter positions. The second control line has two modes. In the first it flips on every line pulse. In the second it flips when the counter reaches either of two programmed positions. The programmed positions come in as static configuration inputs. The line pulse itself comes from elsewhere in the chip.

Top module: `tfco_top`

## Requirements
- R1: After reset the control register is 0, both control pins are 0, and the read port returns 0.
- R2: A write stores bits 3:0 of the write data in the register. The read port returns those four bits and 0 in bits 31:4.
- R3: With register bit 1 at 0 the shift clock output equals the pixel clock. With bit 1 at 1 it is the inverted pixel clock.
- R4: With register bit 2 at 1 the counter restarts at 0 on the clock edge that samples a line pulse, and then adds one per clock. A position P takes effect on edge P+1 after the line-pulse edge. No position matches during a line-pulse cycle.
- R5: With register bit 2 at 0 the counter is held at 0. Control line 0 keeps its value, and so does control line 1 when it is in programmed mode.
- R6: With register bit 3 at 0, control line 1 flips on every edge that samples a line pulse, whether the counter runs or not.
- R7: With register bit 3 at 1, control line 1 ignores line pulses and flips once for each match with the set position or the clear position. When the two positions are equal it flips only once.
- R8: Control line 0 goes to 1 at its on position and to 0 at its off position. When the two positions are equal, the clear takes priority.
- R9: With register bit 0 at 1 the two control lines are exchanged at the output pins. With bit 0 at 0 they pass straight through.
- R10: The counter stops at its all-ones value. That value never matches a programmed position, so no event repeats within a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data |
| linePulse | input | 1 | One-cycle line pulse |
| pixClk | input | 1 | Pixel clock used for the shift clock |
| cfgCtl0On | input | CNT_W | Position where control line 0 rises |
| cfgCtl0Off | input | CNT_W | Position where control line 0 falls |
| cfgCtl1Set | input | CNT_W | First position where control line 1 flips |
| cfgCtl1Clr | input | CNT_W | Second position where control line 1 flips |
| ctl0Pin | output | 1 | Control output pin 0 |
| ctl1Pin | output | 1 | Control output pin 1 |
| shiftClk | output | 1 | Shift clock with selected edge |

## Verification
A register write takes effect one edge after it is sampled. In line mode, control line 1 changes on the edge that samples the line pulse. A counter position P shows at the pins P+1 edges after that pulse edge. Every check counts whole edges from the pulse edge and samples on the falling clock edge that follows. The shift clock and read port are combinational, so they are checked in the same half cycle as the input that drives them.

// File: rtl/tfco_pkg.sv
package tfco_pkg;
  localparam int REG_W    = 4;
  localparam int BIT_SWAP = 0;
  localparam int BIT_EDGE = 1;
  localparam int BIT_RUN  = 2;
  localparam int BIT_MODE = 3;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic ctl0Set;
    logic ctl0Clr;
    logic ctl1Tog;
  } tfcoStrobes_t;
endpackage

// File: rtl/tfco_ctrl.sv
module tfco_ctrl
  import tfco_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [31:0]         regWrData,
  input  logic                linePulse,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [CNT_W-1:0]    cfgCtl0On,
  input  logic [CNT_W-1:0]    cfgCtl0Off,
  input  logic [CNT_W-1:0]    cfgCtl1Set,
  input  logic [CNT_W-1:0]    cfgCtl1Clr,
  output logic [REG_W-1:0]    regQ,
  output tfcoStrobes_t        strobes
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic run;
  logic progMode;
  logic active;
  logic atMax;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else if (regWrEn) regQ <= regWrData[REG_W-1:0];
  end

  assign run      = regQ[BIT_RUN];
  assign progMode = regQ[BIT_MODE];
  assign atMax    = (cnt == CNT_MAX);
  assign active   = run && !linePulse && !atMax;

  always_comb begin
    strobes          = '0;
    strobes.cntClear = !run || linePulse;
    strobes.cntInc   = active;
    strobes.ctl0Set  = active && (cnt == cfgCtl0On);
    strobes.ctl0Clr  = active && (cnt == cfgCtl0Off);
    if (progMode)
      strobes.ctl1Tog = active && ((cnt == cfgCtl1Set) || (cnt == cfgCtl1Clr));
    else
      strobes.ctl1Tog = linePulse;
  end

  // R5
  cnt_stopped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (cnt == '0));

  // R4
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && linePulse) |=> (cnt == '0));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && !linePulse && !atMax) |=> (cnt == $past(cnt) + 1'b1));

  // R10
  cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && !linePulse && atMax) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/tfco_datapath.sv
module tfco_datapath
  import tfco_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  tfcoStrobes_t     strobes,
  output logic [CNT_W-1:0] cnt,
  output logic             ctl0Int,
  output logic             ctl1Int
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strobes.cntClear) cnt <= '0;
    else if (strobes.cntInc)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ctl0Int <= 1'b0;
    else if (strobes.ctl0Clr) ctl0Int <= 1'b0;
    else if (strobes.ctl0Set) ctl0Int <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ctl1Int <= 1'b0;
    else if (strobes.ctl1Tog) ctl1Int <= ~ctl1Int;
  end

  // R8
  ctl0_clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ctl0Set && strobes.ctl0Clr) |=> !ctl0Int);
endmodule

// File: rtl/tfco_top.sv
module tfco_top
  import tfco_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             linePulse,
  input  logic             pixClk,
  input  logic [CNT_W-1:0] cfgCtl0On,
  input  logic [CNT_W-1:0] cfgCtl0Off,
  input  logic [CNT_W-1:0] cfgCtl1Set,
  input  logic [CNT_W-1:0] cfgCtl1Clr,
  output logic             ctl0Pin,
  output logic             ctl1Pin,
  output logic             shiftClk
);
  logic [REG_W-1:0] regQ;
  tfcoStrobes_t     strobes;
  logic [CNT_W-1:0] cnt;
  logic             ctl0Int;
  logic             ctl1Int;

  tfco_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .linePulse(linePulse), .cnt(cnt),
    .cfgCtl0On(cfgCtl0On), .cfgCtl0Off(cfgCtl0Off),
    .cfgCtl1Set(cfgCtl1Set), .cfgCtl1Clr(cfgCtl1Clr),
    .regQ(regQ), .strobes(strobes)
  );

  tfco_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cnt(cnt), .ctl0Int(ctl0Int), .ctl1Int(ctl1Int)
  );

  assign regRdData = {{(32-REG_W){1'b0}}, regQ};
  assign ctl0Pin   = regQ[BIT_SWAP] ? ctl1Int : ctl0Int;
  assign ctl1Pin   = regQ[BIT_SWAP] ? ctl0Int : ctl1Int;
  assign shiftClk  = pixClk ^ regQ[BIT_EDGE];

  // R5
  stopped_hold_ctl0_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regQ[BIT_RUN] |=> $stable(ctl0Int));

  // R5
  stopped_hold_ctl1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regQ[BIT_RUN] && regQ[BIT_MODE]) |=> $stable(ctl1Int));

  // R6
  line_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regQ[BIT_MODE] && linePulse) |=> (ctl1Int != $past(ctl1Int)));

  // R7
  prog_ignores_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regQ[BIT_MODE] && linePulse) |=> $stable(ctl1Int));
endmodule

// File: tb/sim_tfco_top.sv
`timescale 1ns/1ps
module sim_tfco_top;
  localparam int CNT_W = 10;

  typedef struct packed {
    logic [3:0]  regv;
    logic [9:0]  on0;
    logic [9:0]  off0;
    logic [9:0]  set1;
    logic [9:0]  clr1;
    logic [11:0] n;
    logic        exp0;
    logic        exp1;
  } vec_t;

  // regv bits: 3 mode, 2 run, 1 edge, 0 swap
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'b0100, 10'd3, 10'd6, 10'd2, 10'd5, 12'd3, 1'b0, 1'b1},  // R4 R6 before on
    '{4'b0100, 10'd3, 10'd6, 10'd2, 10'd5, 12'd4, 1'b1, 1'b1},  // R4 R8 at on
    '{4'b0100, 10'd3, 10'd6, 10'd2, 10'd5, 12'd7, 1'b0, 1'b1},  // R8 at off
    '{4'b1100, 10'd3, 10'd6, 10'd2, 10'd5, 12'd2, 1'b0, 1'b0},  // R7 no line toggle
    '{4'b1100, 10'd3, 10'd6, 10'd2, 10'd5, 12'd3, 1'b0, 1'b1},  // R7 set point
    '{4'b1100, 10'd3, 10'd6, 10'd2, 10'd5, 12'd6, 1'b1, 1'b0},  // R7 clear point
    '{4'b1101, 10'd3, 10'd6, 10'd2, 10'd5, 12'd6, 1'b0, 1'b1},  // R9 swapped
    '{4'b1100, 10'd3, 10'd9, 10'd4, 10'd4, 12'd5, 1'b1, 1'b1},  // R7 equal points
    '{4'b0100, 10'd4, 10'd4, 10'd2, 10'd5, 12'd5, 1'b0, 1'b1},  // R8 clear wins
    '{4'b0000, 10'd1, 10'd9, 10'd1, 10'd2, 12'd5, 1'b0, 1'b1},  // R5 R6 stopped
    '{4'b0101, 10'd5, 10'd9, 10'd2, 10'd3, 12'd1, 1'b1, 1'b0}   // R9 line mode swap
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic [31:0]      regWrData = '0;
  logic [31:0]      regRdData;
  logic             linePulse = 1'b0;
  logic             pixClk = 1'b0;
  logic [CNT_W-1:0] cfgCtl0On = '0;
  logic [CNT_W-1:0] cfgCtl0Off = '0;
  logic [CNT_W-1:0] cfgCtl1Set = '0;
  logic [CNT_W-1:0] cfgCtl1Clr = '0;
  logic             ctl0Pin;
  logic             ctl1Pin;
  logic             shiftClk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tfco_top #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .linePulse(linePulse), .pixClk(pixClk),
    .cfgCtl0On(cfgCtl0On), .cfgCtl0Off(cfgCtl0Off),
    .cfgCtl1Set(cfgCtl1Set), .cfgCtl1Clr(cfgCtl1Clr),
    .ctl0Pin(ctl0Pin), .ctl1Pin(ctl1Pin), .shiftClk(shiftClk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeReg(input logic [31:0] v);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  // returns at the falling edge n edges after the line-pulse edge
  task automatic pulseAndWait(input int n);
    @(negedge clk);
    linePulse = 1'b1;
    @(negedge clk);
    linePulse = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 read", regRdData, 32'h0);
    check("R1 ctl0", {31'b0, ctl0Pin}, 32'h0);
    check("R1 ctl1", {31'b0, ctl1Pin}, 32'h0);
    rstN = 1'b1;

    // R2 readback and reserved bits
    writeReg(32'hFFFF_FFFA);
    check("R2 readback", regRdData, 32'hA);

    // R3 shift clock edge select
    writeReg(32'h0);
    pixClk = 1'b1; #1;
    check("R3 rising pass", {31'b0, shiftClk}, 32'h1);
    pixClk = 1'b0; #1;
    check("R3 rising pass low", {31'b0, shiftClk}, 32'h0);
    writeReg(32'h2);
    pixClk = 1'b1; #1;
    check("R3 falling inverted", {31'b0, shiftClk}, 32'h0);
    pixClk = 1'b0; #1;
    check("R3 falling inverted low", {31'b0, shiftClk}, 32'h1);

    // table: R4 R6 R7 R8 R9 and R5
    for (int i = 0; i < NV; i++) begin
      doReset();
      cfgCtl0On  = VECS[i].on0;
      cfgCtl0Off = VECS[i].off0;
      cfgCtl1Set = VECS[i].set1;
      cfgCtl1Clr = VECS[i].clr1;
      writeReg({28'b0, VECS[i].regv});
      pulseAndWait(int'(VECS[i].n));
      check($sformatf("vector %0d ctl0 (R4 R5 R8 R9)", i), {31'b0, ctl0Pin}, {31'b0, VECS[i].exp0});
      check($sformatf("vector %0d ctl1 (R6 R7 R9)", i), {31'b0, ctl1Pin}, {31'b0, VECS[i].exp1});
    end

    // R6 two line pulses return control line 1 to 0
    doReset();
    writeReg(32'h4);
    pulseAndWait(0);
    pulseAndWait(0);
    check("R6 double toggle", {31'b0, ctl1Pin}, 32'h0);

    // R5 stopping holds control line 0 high
    doReset();
    cfgCtl0On = 10'd2; cfgCtl0Off = 10'd900;
    writeReg(32'h4);
    pulseAndWait(4);
    check("R5 ctl0 before stop", {31'b0, ctl0Pin}, 32'h1);
    writeReg(32'h0);
    pulseAndWait(5);
    check("R5 ctl0 held while stopped", {31'b0, ctl0Pin}, 32'h1);

    // R10 all-ones position never matches, counter does not wrap
    doReset();
    cfgCtl0On = 10'd1023; cfgCtl0Off = 10'd1022;
    cfgCtl1Set = 10'd1023; cfgCtl1Clr = 10'd1000;
    writeReg(32'hC);
    pulseAndWait(1100);
    check("R10 ctl1 single toggle", {31'b0, ctl1Pin}, 32'h1);
    check("R10 ctl0 max unmatched", {31'b0, ctl0Pin}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule